// File: doc/BRIEF.md
# ADC Result Byte-Output Controller

This block sits between the conversion counter of an integrating analog-to-digital converter and an 8-bit data bus. At the end of each conversion it captures the magnitude count, together with a polarity bit and an over-range bit, into an output latch. A STATUS flag frames the conversion. It rises when input integration begins. It drops half a clock period after the latch has taken the new result, so a host can treat a low STATUS as "data valid and stable".

A host reads the latched result in one of two ways. In direct mode, the MODE input is low and the host selects a byte with chip enable plus one of three byte enables. In handshake mode the block pushes the bytes out by itself, one per cycle, each marked with a load strobe, highest byte first. A single rising edge on MODE sends the current result once. Holding MODE high sends every new result as soon as it is latched. A parameter selects a 16-bit or a 14-bit magnitude. The 16-bit configuration uses three bytes and the 14-bit configuration uses two.

Top module: `adcb_out_top`

## Requirements
- R1: Parameter MAG_W is 16 or 14. A handshake burst is 3 bytes when MAG_W is 16 and 2 bytes when it is 14. The middle byte exists only when MAG_W is 16.
- R2: Direct reads need mode_i low, no burst in progress, chip_en_i high and a byte enable high. When all hold, data_oe_o is 1 and data_o shows the selected latched byte in the same cycle. Otherwise data_oe_o is 0 and data_o is 0. Enable priority is high, then middle, then low. A middle enable counts as deasserted when MAG_W is 14.
- R3: Byte layout with MAG_W=16: low byte = count[7:0], middle byte = count[15:8], high byte = {pol, ovr, 6'b0} (pol in bit 7, ovr in bit 6). With MAG_W=14: low byte = count[7:0], high byte = {pol, ovr, count[13:8]}.
- R4: If integ_start_i is high at a rising clock edge, status_o is high right after that edge.
- R5: If result_rdy_i is high at a rising edge while status_o is high, that edge latches {pol_i, ovr_i, count_i}. status_o stays high until the following falling edge and is low after it. If integ_start_i is high at the same edge, status_o stays high.
- R6: result_rdy_i at a rising edge while status_o is low is ignored: the latched result does not change.
- R7: A rising edge of mode_i (low at the previous clock edge, high at this one) starts one burst of the currently latched result. Once mode_i is low again, later conversions start no burst.
- R8: While mode_i stays high, every latch event from R5 starts a burst that carries the newly latched result.
- R9: A burst starts with the clock cycle after its triggering edge and lasts one cycle per byte. In each of those cycles load_o=1 and data_oe_o=1, and the bytes come out high, middle (16-bit only), low. load_o is 0 in every other cycle.
- R10: A trigger that arrives while a burst is in progress is dropped. A burst sends the result as it stood at its start, even if the latch is updated during the burst.
- R11: After reset, status_o=0, load_o=0, data_oe_o=0 and the latched result is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; STATUS also uses its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Low: direct reads; rising edge: one burst; held high: burst per conversion |
| chip_en_i | input | 1 | Chip enable for direct reads |
| ben_lo_i | input | 1 | Low byte enable |
| ben_mid_i | input | 1 | Middle byte enable (16-bit only) |
| ben_hi_i | input | 1 | High byte enable |
| result_rdy_i | input | 1 | Conversion done, result on count/pol/ovr |
| integ_start_i | input | 1 | Input integration begins |
| count_i | input | MAG_W | Magnitude count |
| pol_i | input | 1 | Polarity of the result |
| ovr_i | input | 1 | Over-range flag |
| data_o | output | 8 | Byte bus |
| data_oe_o | output | 1 | Byte bus drive enable (models tri-state) |
| load_o | output | 1 | Marks each byte of a handshake burst |
| status_o | output | 1 | Conversion in progress / data not yet valid |

## Verification
The assertions check the following on every cycle: STATUS rises after an integrate start, STATUS is low one edge after a latch, the latch holds while STATUS is low, a burst opens with its top index and keeps a frozen snapshot, and the bus is driven in direct mode only with chip enable and MODE low. Only the bench scenarios can show the actual byte values in each layout, the half-period position of the STATUS fall, and the difference between the one-shot and continuous MODE behaviours. They also show that a dropped retrigger yields exactly one burst, whose bytes are taken from before a mid-burst latch update.

// File: rtl/adcb_pkg.sv
package adcb_pkg;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_MID  = 2'd1,
    SEL_HI   = 2'd2,
    SEL_NONE = 2'd3
  } bsel_e;

  typedef struct packed {
    logic        pol;
    logic        ovr;
    logic [15:0] mag;
  } result_t;

  // number of bytes a result occupies for a given magnitude width
  function automatic int unsigned bytes_for(input int unsigned w);
    return (w > 14) ? 3 : 2;
  endfunction

  // byte layout of a result for the given selector
  function automatic logic [7:0] pick_byte(input result_t r, input bsel_e s,
                                           input int unsigned w);
    logic [7:0] b;
    b = '0;
    unique case (s)
      SEL_LO:  b = r.mag[7:0];
      SEL_MID: b = (w > 14) ? r.mag[15:8] : 8'h00;
      SEL_HI:  b = (w > 14) ? {r.pol, r.ovr, 6'b000000}
                            : {r.pol, r.ovr, r.mag[13:8]};
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  // burst index counts down from nb-1 to 0
  function automatic bsel_e burst_sel(input logic [1:0] idx, input int unsigned nb);
    if (idx == 2'd0)                  return SEL_LO;
    else if (32'(idx) == nb - 1)      return SEL_HI;
    else                              return SEL_MID;
  endfunction

  // direct-mode byte selection with priority high > middle > low
  function automatic bsel_e direct_sel(input logic hi, input logic mid,
                                       input logic lo, input int unsigned w);
    if (hi)                return SEL_HI;
    else if (mid && w > 14) return SEL_MID;
    else if (lo)           return SEL_LO;
    else                   return SEL_NONE;
  endfunction

endpackage

// File: rtl/adcb_status.sv
module adcb_status
  import adcb_pkg::*;
#(
  parameter int unsigned MAG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             integ_start_i,
  input  logic             result_rdy_i,
  input  logic [MAG_W-1:0] count_i,
  input  logic             pol_i,
  input  logic             ovr_i,
  output result_t          lat_o,
  output logic             latch_evt_o,
  output logic             status_o
);

  logic    stat_q;   // rising-edge part of STATUS
  logic    stat_nq;  // falling-edge copy, delays the fall by half a period
  result_t lat_q;

  assign latch_evt_o = result_rdy_i & stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              stat_q <= 1'b0;
    else if (integ_start_i)  stat_q <= 1'b1;
    else if (latch_evt_o)    stat_q <= 1'b0;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) stat_nq <= 1'b0;
    else        stat_nq <= stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (latch_evt_o) begin
      lat_q.pol <= pol_i;
      lat_q.ovr <= ovr_i;
      lat_q.mag <= 16'(count_i);
    end
  end

  assign status_o = stat_q | stat_nq;
  assign lat_o    = lat_q;

  // R4: integrate start raises STATUS
  a_r4_status_rise: assert property (@(posedge clk) disable iff (!rst_n)
    integ_start_i |=> status_o);

  // R5: a latch without a new integrate start leaves STATUS low by the next edge
  a_r5_status_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt_o && !integ_start_i) |=> !status_o);

  // R6: latch contents never move while STATUS is low
  a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o |=> $stable(lat_q));

endmodule

// File: rtl/adcb_seq.sv
module adcb_seq
  import adcb_pkg::*;
#(
  parameter int unsigned MAG_W = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    mode_i,
  input  logic    latch_evt_i,
  input  result_t lat_i,
  input  result_t new_i,
  output logic    busy_o,
  output bsel_e   sel_o,
  output result_t snap_o,
  output logic    trig_o,
  output logic    drop_o
);

  localparam int unsigned NB = bytes_for(MAG_W);

  logic       mode_q;
  logic       busy_q;
  logic [1:0] idx_q;
  result_t    snap_q;
  logic       mode_rise;
  logic       start;

  assign mode_rise = mode_i & ~mode_q;
  assign trig_o    = mode_rise | (mode_i & latch_evt_i);
  assign start     = trig_o & ~busy_q;
  assign drop_o    = trig_o & busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      snap_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= 2'(NB - 1);
      snap_q <= latch_evt_i ? new_i : lat_i;
    end else if (busy_q) begin
      if (idx_q == 2'd0) busy_q <= 1'b0;
      else               idx_q  <= idx_q - 2'd1;
    end
  end

  assign busy_o = busy_q;
  assign sel_o  = busy_q ? burst_sel(idx_q, NB) : SEL_NONE;
  assign snap_o = snap_q;

  // R9: every burst opens with the highest byte
  a_r9_burst_open: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (sel_o == SEL_HI));

  // R10: mid-burst the snapshot is frozen and the burst continues
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q != 2'd0) |=> (busy_q && $stable(snap_q)));

endmodule

// File: rtl/adcb_bus.sv
module adcb_bus
  import adcb_pkg::*;
#(
  parameter int unsigned MAG_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_i,
  input  logic       chip_en_i,
  input  logic       ben_lo_i,
  input  logic       ben_mid_i,
  input  logic       ben_hi_i,
  input  logic       busy_i,
  input  bsel_e      burst_sel_i,
  input  result_t    snap_i,
  input  result_t    lat_i,
  output logic [7:0] data_o,
  output logic       data_oe_o,
  output logic       load_o
);

  bsel_e dsel;

  assign dsel = direct_sel(ben_hi_i, ben_mid_i, ben_lo_i, MAG_W);

  always_comb begin
    data_o    = 8'h00;
    data_oe_o = 1'b0;
    load_o    = 1'b0;
    if (busy_i) begin
      data_o    = pick_byte(snap_i, burst_sel_i, MAG_W);
      data_oe_o = 1'b1;
      load_o    = 1'b1;
    end else if (!mode_i && chip_en_i && dsel != SEL_NONE) begin
      data_o    = pick_byte(lat_i, dsel, MAG_W);
      data_oe_o = 1'b1;
    end
  end

  // R2: outside a burst the bus is driven only for an enabled direct read
  a_r2_direct_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe_o && !load_o) |-> (chip_en_i && !mode_i));

endmodule

// File: rtl/adcb_out_top.sv
module adcb_out_top
  import adcb_pkg::*;
#(
  parameter int unsigned MAG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             chip_en_i,
  input  logic             ben_lo_i,
  input  logic             ben_mid_i,
  input  logic             ben_hi_i,
  input  logic             result_rdy_i,
  input  logic             integ_start_i,
  input  logic [MAG_W-1:0] count_i,
  input  logic             pol_i,
  input  logic             ovr_i,
  output logic [7:0]       data_o,
  output logic             data_oe_o,
  output logic             load_o,
  output logic             status_o
);

  result_t lat;
  result_t incoming;
  result_t snap;
  logic    latch_evt;
  logic    busy;
  logic    trig;
  logic    drop;
  bsel_e   bsel;

  assign incoming.pol = pol_i;
  assign incoming.ovr = ovr_i;
  assign incoming.mag = 16'(count_i);

  adcb_status #(.MAG_W(MAG_W)) u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .integ_start_i(integ_start_i),
    .result_rdy_i (result_rdy_i),
    .count_i      (count_i),
    .pol_i        (pol_i),
    .ovr_i        (ovr_i),
    .lat_o        (lat),
    .latch_evt_o  (latch_evt),
    .status_o     (status_o)
  );

  adcb_seq #(.MAG_W(MAG_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .latch_evt_i(latch_evt),
    .lat_i      (lat),
    .new_i      (incoming),
    .busy_o     (busy),
    .sel_o      (bsel),
    .snap_o     (snap),
    .trig_o     (trig),
    .drop_o     (drop)
  );

  adcb_bus #(.MAG_W(MAG_W)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .chip_en_i  (chip_en_i),
    .ben_lo_i   (ben_lo_i),
    .ben_mid_i  (ben_mid_i),
    .ben_hi_i   (ben_hi_i),
    .busy_i     (busy),
    .burst_sel_i(bsel),
    .snap_i     (snap),
    .lat_i      (lat),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o),
    .load_o     (load_o)
  );

  // R1: width parameter limited to the two supported configurations
  a_r1_width: assert property (@(posedge clk) disable iff (!rst_n)
    (MAG_W == 16 || MAG_W == 14) && !(trig && drop && !busy));

endmodule

// File: tb/adcb_out_top_tb_top.sv
module adcb_out_top_tb_top;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0, ce = 1'b0, blo = 1'b0, bmid = 1'b0, bhi = 1'b0;
  logic        rdy = 1'b0, integ = 1'b0, pol = 1'b0, ovr = 1'b0;
  logic [15:0] cnt = 16'h0;
  logic [7:0]  d16, d14;
  logic        oe16, ld16, st16, oe14, ld14, st14;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  adcb_out_top #(.MAG_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .chip_en_i(ce),
    .ben_lo_i(blo), .ben_mid_i(bmid), .ben_hi_i(bhi),
    .result_rdy_i(rdy), .integ_start_i(integ), .count_i(cnt),
    .pol_i(pol), .ovr_i(ovr),
    .data_o(d16), .data_oe_o(oe16), .load_o(ld16), .status_o(st16));

  adcb_out_top #(.MAG_W(14)) dut14_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .chip_en_i(ce),
    .ben_lo_i(blo), .ben_mid_i(bmid), .ben_hi_i(bhi),
    .result_rdy_i(rdy), .integ_start_i(integ), .count_i(cnt[13:0]),
    .pol_i(pol), .ovr_i(ovr),
    .data_o(d14), .data_oe_o(oe14), .load_o(ld14), .status_o(st14));

  // {pol, ovr, count}
  localparam logic [17:0] VEC [4] = '{
    {1'b1, 1'b0, 16'hA5C3},
    {1'b0, 1'b1, 16'hFFFF},
    {1'b0, 1'b0, 16'h0000},
    {1'b1, 1'b1, 16'h3C81}
  };

  // expected byte: which 0=low, 1=middle, 2=high
  function automatic logic [7:0] exp_b(bit wide, logic p, logic o,
                                       logic [15:0] c, int which);
    logic [15:0] sh;
    if (which == 0) return c[7:0];
    if (which == 1) begin
      sh = c >> 8;
      return wide ? sh[7:0] : 8'h00;
    end
    sh = {8'h00, p, o, 6'b0} | (wide ? 16'h0 : {10'h0, c[13:8]});
    return sh[7:0];
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic convert(logic p, logic o, logic [15:0] c);
    integ = 1'b1;
    cyc();
    integ = 1'b0;
    pol = p; ovr = o; cnt = c; rdy = 1'b1;
    cyc();
    rdy = 1'b0;
  endtask

  task automatic set_ben(int which);
    blo = (which == 0); bmid = (which == 1); bhi = (which == 2);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [15:0] old_c;
    logic        old_p, old_o;

    // reset state (R11)
    cyc(); cyc();
    chk("R11", "status in reset", st16, 0);
    chk("R11", "load in reset", ld16, 0);
    chk("R11", "oe in reset", oe16, 0);
    rst_n = 1'b1;
    cyc();
    ce = 1'b1; set_ben(0); #2;
    chk("R11", "latch zero after reset", {oe16, d16}, {1'b1, 8'h00});
    set_ben(2); #1;
    chk("R11", "high byte zero after reset", d16, 8'h00);
    set_ben(3); ce = 1'b0;

    // table walk: direct reads of each layout (R1 R2 R3)
    for (int i = 0; i < 4; i++) begin
      convert(VEC[i][17], VEC[i][16], VEC[i][15:0]);
      ce = 1'b1;
      for (int w = 0; w < 3; w++) begin
        set_ben(w); #2;
        chk("R3", "16-bit byte", {oe16, d16},
            {1'b1, exp_b(1'b1, VEC[i][17], VEC[i][16], VEC[i][15:0], w)});
        if (w == 1)
          chk("R1", "14-bit middle absent", oe14, 0);
        else
          chk("R3", "14-bit byte", {oe14, d14},
              {1'b1, exp_b(1'b0, VEC[i][17], VEC[i][16], VEC[i][15:0], w)});
      end
      set_ben(3);
      ce = 1'b0;
    end

    // R2: gating and priority
    set_ben(2); #1;
    chk("R2", "no chip enable", {oe16, d16}, 9'h000);
    ce = 1'b1; blo = 1'b1; #1;
    chk("R2", "high beats low", d16, exp_b(1'b1, 1'b1, 1'b1, 16'h3C81, 2));
    bhi = 1'b0; bmid = 1'b1; #1;
    chk("R2", "14-bit mid ignored, low read", d14, 8'h81);
    set_ben(3); ce = 1'b0;

    // R4 / R5 STATUS timing
    cyc();
    integ = 1'b1;
    cyc();
    integ = 1'b0;
    chk("R4", "status after integrate start", st16, 1);
    cyc();
    pol = 1'b0; ovr = 1'b0; cnt = 16'h1234; rdy = 1'b1;
    cyc();
    rdy = 1'b0;
    #2 chk("R5", "status high before falling edge", st16, 1);
    #4 chk("R5", "status low after falling edge", st16, 0);
    chk("R5", "14-bit status low", st14, 0);
    cyc();
    integ = 1'b1;
    cyc();
    integ = 1'b1; rdy = 1'b1; cnt = 16'h4321;
    cyc();
    integ = 1'b0; rdy = 1'b0;
    #6 chk("R5", "integrate start overrides fall", st16, 1);
    cyc();
    cnt = 16'h0F0F; rdy = 1'b1;
    cyc();
    rdy = 1'b0;
    cyc();

    // R6: result ready while STATUS low is ignored
    cnt = 16'hBEEF; pol = 1'b1; rdy = 1'b1;
    cyc();
    rdy = 1'b0;
    ce = 1'b1; set_ben(0); #2;
    chk("R6", "latch unchanged", d16, 8'h0F);
    chk("R6", "status stays low", st16, 0);
    set_ben(3); ce = 1'b0;

    // R7 / R9 one-shot burst of current result {0,0,0F0F}
    cyc();
    mode = 1'b1;
    cyc();
    mode = 1'b0;
    #2;
    chk("R9", "burst byte 1 16-bit", {ld16, oe16, d16}, {2'b11, 8'h00});
    chk("R9", "burst byte 1 14-bit", {ld14, d14}, {1'b1, 8'h0F});
    cyc(); #2;
    chk("R9", "burst byte 2 16-bit", {ld16, d16}, {1'b1, 8'h0F});
    chk("R1", "burst byte 2 14-bit", {ld14, d14}, {1'b1, 8'h0F});
    cyc(); #2;
    chk("R9", "burst byte 3 16-bit", {ld16, d16}, {1'b1, 8'h0F});
    chk("R1", "14-bit burst ended", ld14, 0);
    cyc(); #2;
    chk("R1", "16-bit burst ended", ld16, 0);
    convert(1'b1, 1'b0, 16'h2222);
    #2 chk("R7", "no burst after one-shot", {ld16, ld14}, 2'b00);
    cyc();
    chk("R7", "still no burst", {ld16, ld14}, 2'b00);

    // R8 continuous mode
    mode = 1'b1;
    for (int k = 0; k < 5; k++) cyc();
    convert(1'b1, 1'b1, 16'h5A3C);
    #2;
    chk("R8", "auto burst high 16", {ld16, d16}, {1'b1, 8'hC0});
    chk("R8", "auto burst high 14", {ld14, d14}, {1'b1, 8'hDA});
    cyc(); #2;
    chk("R8", "auto burst mid 16", d16, 8'h5A);
    chk("R8", "auto burst low 14", d14, 8'h3C);
    cyc(); #2;
    chk("R8", "auto burst low 16", d16, 8'h3C);
    cyc();
    convert(1'b0, 1'b1, 16'h0177);
    #2;
    chk("R8", "second auto burst high 16", {ld16, d16}, {1'b1, 8'h40});
    cyc(); cyc(); #2;
    chk("R8", "second auto burst low 16", {ld16, d16}, {1'b1, 8'h77});
    mode = 1'b0;
    cyc(); cyc();

    // R10: retrigger and latch update during a burst
    old_c = 16'h0177; old_p = 1'b0; old_o = 1'b1;
    integ = 1'b1;
    cyc();
    integ = 1'b0;
    mode = 1'b1;
    cyc();
    mode = 1'b0;
    #2 chk("R10", "high byte before update", d16, exp_b(1'b1, old_p, old_o, old_c, 2));
    cyc();
    mode = 1'b1; rdy = 1'b1; cnt = 16'hE7D6; pol = 1'b1; ovr = 1'b0;
    #2 chk("R10", "middle byte from snapshot", d16, exp_b(1'b1, old_p, old_o, old_c, 1));
    cyc();
    mode = 1'b0; rdy = 1'b0;
    #2 chk("R10", "low byte from snapshot", {ld16, d16}, {1'b1, old_c[7:0]});
    cyc(); #2;
    chk("R10", "retrigger dropped", {ld16, ld14}, 2'b00);
    cyc(); #2;
    chk("R10", "no late burst", {ld16, ld14}, 2'b00);
    ce = 1'b1; set_ben(0); #1;
    chk("R10", "latch updated during burst", d16, 8'hD6);
    set_ben(3); ce = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule